// File: doc/BRIEF.md
# Multicast Mesh Write Router Node

This block is a single router node for a two-dimensional mesh that carries write traffic. It has five input ports and five output ports. Four of each face the north, south, east and west neighbours. The fifth input takes traffic injected by the local agent, and the fifth output delivers traffic to it. Every transaction carries a write flag, a 2-bit size code, a 4-bit control-mode field, an address and data. Each port uses a valid/ready handshake. All output ports share one payload bus, and each output has its own valid.

Ordinary transactions are steered by their destination coordinates, column first and then row. A write tagged with the multicast control-mode code floods the whole mesh so that each node sees exactly one copy. Vertical copies travel only along the sender's column and never reverse direction. Every node in that column spawns one eastward and one westward copy. A horizontal copy keeps moving away from the side it arrived on. Each node hands a multicast write to its local agent when the upper address bits equal the node's group value.

A single round-robin arbiter serves one input at a time. A multicast fan-out keeps its input locked until every required output has taken its copy, so backpressure on one side never drops or duplicates a copy on another side.

Top module: `mcn_node`

## Requirements
- R1: A transaction that is not multicast takes its destination row from addr[31:26] and its destination column from addr[25:20]. It goes east if the column is greater than col_id and west if it is smaller. With equal columns it goes south if the row is greater than row_id, north if it is smaller, and to the local output if both match. Rows grow southward and columns grow eastward.
- R2: A transaction is multicast only when write=1, ctrl=4'h3 and size is not 2'b11. Size codes 0..3 mean 8, 16, 32 and 64 bits.
- R3: A read, or a 64-bit write (size 2'b11), that carries ctrl=4'h3 is routed exactly as R1 describes.
- R4: A multicast write is offered on the local output when addr[31:20] equals group_id. No enable gates this match.
- R5: The outputs a multicast write is forwarded to depend on the input it arrived on. Port indices are north 0, south 1, east 2, west 3, local 4.
  - From local injection it goes north, south, east and west.
  - From the south port it goes north, east and west.
  - From the north port it goes south, east and west.
  - From the west port it goes east only.
  - From the east port it goes west only.
  - It is never sent back out of the port it arrived on.
- R6: A multicast copy is never offered toward the mesh edge:
  - not north at row 0;
  - not south at row ROWS-1;
  - not west at column 0;
  - not east at column COLS-1.
  A multicast write left with no destination is consumed at once.
- R7: All copies of one transaction are offered in the same cycle that the input is granted. The payload is unchanged on the shared output bus.
- R8: The granted input sees ready only in the cycle in which every required output has accepted its copy. An output that has already accepted a copy is not offered that transaction again.
- R9: Inputs are served round-robin in index order. The search starts at index 0 after reset and, after each completed transaction, starts at the index after the one served. A partly accepted transaction keeps the grant.
- R10: After reset, with no input valid, no output is valid and no input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| row_id | input | CW | This node's row |
| col_id | input | CW | This node's column |
| group_id | input | 2*CW | Multicast group value compared with the upper address bits |
| in_valid | input | 5 | Per-input valid (N,S,E,W,L) |
| in_ready | output | 5 | Per-input ready |
| in_write | input | 5 | Per-input write flag |
| in_size | input | 10 | Per-input 2-bit size code |
| in_ctrl | input | 20 | Per-input 4-bit control mode |
| in_addr | input | 5*AW | Per-input address |
| in_data | input | 5*DW | Per-input data |
| out_valid | output | 5 | Per-output valid (N,S,E,W,L) |
| out_ready | input | 5 | Per-output ready |
| out_write | output | 1 | Shared payload write flag |
| out_size | output | 2 | Shared payload size code |
| out_ctrl | output | 4 | Shared payload control mode |
| out_addr | output | AW | Shared payload address |
| out_data | output | DW | Shared payload data |

## Verification
The grant, the output valids and the input ready are combinational from the registered lock and accepted-copy state. All three are therefore due in the same cycle the stimulus is applied. The bench drives at the falling edge and samples 1 ns later, before the next rising edge. The accepted-copy mask and the round-robin pointer change only at the rising edge. Follow-up checks after partial acceptance, and the grant order across back-to-back transactions, are sampled in the following cycle.

// File: rtl/mcn_pkg.sv
package mcn_pkg;
    localparam int NP   = 5;
    localparam int P_N  = 0;
    localparam int P_S  = 1;
    localparam int P_E  = 2;
    localparam int P_W  = 3;
    localparam int P_L  = 4;
    localparam logic [1:0] SZ_64 = 2'b11;

    typedef struct packed {
        logic       lock;
        logic [2:0] sel;
        logic [2:0] rr;
    } arb_st_t;

    typedef struct packed {
        logic [NP-1:0] done;
    } fan_st_t;
endpackage

// File: rtl/mcn_route.sv
module mcn_route
    import mcn_pkg::*;
#(
    parameter int         CW      = 6,
    parameter int         ROWS    = 4,
    parameter int         COLS    = 4,
    parameter int         SRC     = 4,
    parameter logic [3:0] MC_CODE = 4'h3
) (
    input  logic            wr,
    input  logic [1:0]      sz,
    input  logic [3:0]      ctrl,
    input  logic [2*CW-1:0] addr_hi,
    input  logic [CW-1:0]   row_id,
    input  logic [CW-1:0]   col_id,
    input  logic [2*CW-1:0] group_id,
    output logic            is_mc,
    output logic [NP-1:0]   dest
);
    localparam logic [CW-1:0] LAST_ROW = CW'(ROWS - 1);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    logic [CW-1:0] dst_row;
    logic [CW-1:0] dst_col;

    assign dst_row = addr_hi[2*CW-1 -: CW];
    assign dst_col = addr_hi[CW-1:0];

    always_comb begin
        is_mc = wr && (ctrl == MC_CODE) && (sz != SZ_64);
        dest  = '0;
        if (is_mc) begin
            dest[P_L] = (addr_hi == group_id);
            if (SRC == P_L) begin
                dest[P_N] = 1'b1;
                dest[P_S] = 1'b1;
                dest[P_E] = 1'b1;
                dest[P_W] = 1'b1;
            end else if (SRC == P_S) begin
                dest[P_N] = 1'b1;
                dest[P_E] = 1'b1;
                dest[P_W] = 1'b1;
            end else if (SRC == P_N) begin
                dest[P_S] = 1'b1;
                dest[P_E] = 1'b1;
                dest[P_W] = 1'b1;
            end else if (SRC == P_W) begin
                dest[P_E] = 1'b1;
            end else begin
                dest[P_W] = 1'b1;
            end
            if (row_id == '0)      dest[P_N] = 1'b0;
            if (row_id == LAST_ROW) dest[P_S] = 1'b0;
            if (col_id == '0)      dest[P_W] = 1'b0;
            if (col_id == LAST_COL) dest[P_E] = 1'b0;
        end else begin
            if (dst_col > col_id)      dest[P_E] = 1'b1;
            else if (dst_col < col_id) dest[P_W] = 1'b1;
            else if (dst_row > row_id) dest[P_S] = 1'b1;
            else if (dst_row < row_id) dest[P_N] = 1'b1;
            else                       dest[P_L] = 1'b1;
        end
    end
endmodule

// File: rtl/mcn_arb.sv
module mcn_arb
    import mcn_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] in_valid,
    input  logic          fire,
    output logic          active,
    output logic [2:0]    sel
);
    arb_st_t st_d, st_q;
    logic [2:0] pick;
    logic       found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < NP; i++) begin
            int idx;
            idx = int'(st_q.rr) + i;
            if (idx >= NP) idx = idx - NP;
            if (!found && in_valid[idx]) begin
                found = 1'b1;
                pick  = 3'(idx);
            end
        end
        active = st_q.lock || found;
        sel    = st_q.lock ? st_q.sel : pick;

        st_d = st_q;
        if (active) begin
            if (fire) begin
                st_d.lock = 1'b0;
                st_d.rr   = (sel == 3'(NP - 1)) ? 3'd0 : sel + 3'd1;
            end else begin
                st_d.lock = 1'b1;
                st_d.sel  = sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fire) |=> (active && sel == $past(sel)));
endmodule

// File: rtl/mcn_fanout.sv
module mcn_fanout
    import mcn_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [NP-1:0] dest,
    input  logic [NP-1:0] out_ready,
    output logic [NP-1:0] out_valid,
    output logic          all_done
);
    fan_st_t st_d, st_q;
    logic [NP-1:0] acc;

    always_comb begin
        out_valid = {NP{active}} & dest & ~st_q.done;
        acc       = out_valid & out_ready;
        all_done  = active && (((st_q.done | acc) & dest) == dest);
        st_d      = st_q;
        if (!active || all_done) st_d.done = '0;
        else                     st_d.done = st_q.done | acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < NP; k++) begin : g_chk
        // R8
        no_reoffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[k] && out_ready[k] && !all_done) |=> !out_valid[k]);
        // R8
        copy_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[k] && !out_ready[k]) |=> out_valid[k]);
    end
endmodule

// File: rtl/mcn_node.sv
module mcn_node
    import mcn_pkg::*;
#(
    parameter int         AW      = 32,
    parameter int         DW      = 32,
    parameter int         CW      = 6,
    parameter int         ROWS    = 4,
    parameter int         COLS    = 4,
    parameter logic [3:0] MC_CODE = 4'h3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    row_id,
    input  logic [CW-1:0]    col_id,
    input  logic [2*CW-1:0]  group_id,
    input  logic [NP-1:0]    in_valid,
    output logic [NP-1:0]    in_ready,
    input  logic [NP-1:0]    in_write,
    input  logic [2*NP-1:0]  in_size,
    input  logic [4*NP-1:0]  in_ctrl,
    input  logic [NP*AW-1:0] in_addr,
    input  logic [NP*DW-1:0] in_data,
    output logic [NP-1:0]    out_valid,
    input  logic [NP-1:0]    out_ready,
    output logic             out_write,
    output logic [1:0]       out_size,
    output logic [3:0]       out_ctrl,
    output logic [AW-1:0]    out_addr,
    output logic [DW-1:0]    out_data
);
    localparam int HW = 2 * CW;

    logic [NP-1:0] dest_all [NP];
    logic [NP-1:0] is_mc;
    logic          active;
    logic [2:0]    sel;
    logic          all_done;
    logic [NP-1:0] dest_sel;

    for (genvar g = 0; g < NP; g++) begin : g_route
        mcn_route #(
            .CW(CW), .ROWS(ROWS), .COLS(COLS), .SRC(g), .MC_CODE(MC_CODE)
        ) route_i (
            .wr      (in_write[g]),
            .sz      (in_size[2*g +: 2]),
            .ctrl    (in_ctrl[4*g +: 4]),
            .addr_hi (in_addr[g*AW+AW-1 -: HW]),
            .row_id  (row_id),
            .col_id  (col_id),
            .group_id(group_id),
            .is_mc   (is_mc[g]),
            .dest    (dest_all[g])
        );
    end

    mcn_arb arb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .fire    (all_done),
        .active  (active),
        .sel     (sel)
    );

    always_comb begin
        dest_sel  = '0;
        out_write = 1'b0;
        out_size  = '0;
        out_ctrl  = '0;
        out_addr  = '0;
        out_data  = '0;
        for (int i = 0; i < NP; i++) begin
            if (sel == 3'(i)) begin
                dest_sel  = dest_all[i];
                out_write = in_write[i];
                out_size  = in_size[2*i +: 2];
                out_ctrl  = in_ctrl[4*i +: 4];
                out_addr  = in_addr[i*AW +: AW];
                out_data  = in_data[i*DW +: DW];
            end
        end
    end

    mcn_fanout fan_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .dest     (dest_sel),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .all_done (all_done)
    );

    always_comb begin
        in_ready = '0;
        for (int i = 0; i < NP; i++)
            if (all_done && sel == 3'(i)) in_ready[i] = 1'b1;
    end

    // R9
    one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));

    // R6
    north_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && is_mc[sel] && row_id == '0) |-> !out_valid[P_N]);

    // R6
    west_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && is_mc[sel] && col_id == '0) |-> !out_valid[P_W]);

    for (genvar g = 0; g < 4; g++) begin : g_back
        // R5
        no_backflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (active && sel == 3'(g) && is_mc[g]) |-> !out_valid[g]);
    end
endmodule

// File: tb/mcn_node_tb.sv
`timescale 1ns/1ps
module mcn_node_tb_top;
    localparam int AW = 32, DW = 32, CW = 6, NP = 5;
    localparam logic [3:0] MC = 4'h3;
    localparam logic [11:0] GRP = 12'h2C5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [CW-1:0]    row_id, col_id;
    logic [2*CW-1:0]  group_id;
    logic [NP-1:0]    in_valid, in_ready, in_write, out_valid, out_ready;
    logic [2*NP-1:0]  in_size;
    logic [4*NP-1:0]  in_ctrl;
    logic [NP*AW-1:0] in_addr;
    logic [NP*DW-1:0] in_data;
    logic             out_write;
    logic [1:0]       out_size;
    logic [3:0]       out_ctrl;
    logic [AW-1:0]    out_addr;
    logic [DW-1:0]    out_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    mcn_node dut_i (
        .clk(clk), .rst_n(rst_n), .row_id(row_id), .col_id(col_id), .group_id(group_id),
        .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write), .in_size(in_size),
        .in_ctrl(in_ctrl), .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_write(out_write), .out_size(out_size),
        .out_ctrl(out_ctrl), .out_addr(out_addr), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_mask(input int src, input int r, input int c,
        input bit w, input logic [1:0] sz, input logic [3:0] ct, input logic [31:0] a);
        logic [4:0] m;
        int dr, dc;
        m = '0;
        if (w && ct == MC && sz != 2'b11) begin
            if (a[31:20] == GRP) m[4] = 1'b1;
            case (src)
                4: m[3:0] = 4'b1111;
                1: m[3:0] = 4'b1101;
                0: m[3:0] = 4'b1110;
                3: m[3:0] = 4'b0100;
                default: m[3:0] = 4'b1000;
            endcase
            if (r == 0) m[0] = 1'b0;
            if (r == 3) m[1] = 1'b0;
            if (c == 0) m[3] = 1'b0;
            if (c == 3) m[2] = 1'b0;
        end else begin
            dr = int'(a[31:26]);
            dc = int'(a[25:20]);
            if (dc > c) m[2] = 1'b1;
            else if (dc < c) m[3] = 1'b1;
            else if (dr > r) m[1] = 1'b1;
            else if (dr < r) m[0] = 1'b1;
            else m[4] = 1'b1;
        end
        return m;
    endfunction

    task automatic set_in(input int s, input bit w, input logic [1:0] sz,
                          input logic [3:0] ct, input logic [31:0] a, input logic [31:0] d);
        in_valid[s]       = 1'b1;
        in_write[s]       = w;
        in_size[2*s +: 2] = sz;
        in_ctrl[4*s +: 4] = ct;
        in_addr[s*AW +: AW] = a;
        in_data[s*DW +: DW] = d;
    endtask

    task automatic run_txn(input string req, input int s, input int r, input int c, input bit w,
                           input logic [1:0] sz, input logic [3:0] ct, input logic [31:0] a);
        logic [4:0] em;
        logic [31:0] d;
        d = a ^ 32'h5A5A_0000 ^ 32'(s);
        @(negedge clk);
        row_id = CW'(r); col_id = CW'(c);
        set_in(s, w, sz, ct, a, d);
        #1;
        em = exp_mask(s, r, c, w, sz, ct, a);
        chk(out_valid == em, req, 64'(out_valid), 64'(em));
        chk(in_ready == 5'(1 << s), {req, " R8 ready"}, 64'(in_ready), 64'(1 << s));
        if (em != 0)
            chk(out_data == d && out_addr == a, {req, " R7 payload"}, 64'(out_data), 64'(d));
        @(posedge clk); #1;
        in_valid = '0;
    endtask

    initial begin
        in_valid = '0; in_write = '0; in_size = '0; in_ctrl = '0; in_addr = '0; in_data = '0;
        out_ready = '1; row_id = 6'd2; col_id = 6'd2; group_id = GRP;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk(out_valid == 0, "R10 out_valid", 64'(out_valid), 0);
        chk(in_ready == 0, "R10 in_ready", 64'(in_ready), 0);
        rst_n = 1'b1;

        // R9 round robin: south(1) and west(3) unicast to own node
        @(negedge clk);
        set_in(1, 1'b1, 2'b10, 4'h0, {6'd2, 6'd2, 20'h00040}, 32'h11);
        set_in(3, 1'b1, 2'b10, 4'h0, {6'd2, 6'd2, 20'h00080}, 32'h33);
        #1;
        chk(in_ready == 5'b00010, "R9 first grant", 64'(in_ready), 64'h2);
        chk(out_valid == 5'b10000, "R1 local unicast", 64'(out_valid), 64'h10);
        @(negedge clk); #1;
        chk(in_ready == 5'b01000, "R9 second grant", 64'(in_ready), 64'h8);
        @(negedge clk); #1;
        chk(in_ready == 5'b00010, "R9 third grant", 64'(in_ready), 64'h2);
        @(posedge clk); #1;
        in_valid = '0;

        // R8 backpressure: local multicast at (1,1) plus north unicast competing
        @(negedge clk);
        row_id = 6'd1; col_id = 6'd1;
        set_in(4, 1'b1, 2'b10, MC, {GRP, 20'h00010}, 32'hCAFE);
        set_in(0, 1'b1, 2'b10, 4'h0, {6'd1, 6'd1, 20'h0}, 32'hBEEF);
        out_ready = 5'b10001;
        #1;
        chk(out_valid == 5'b11111, "R7 all copies", 64'(out_valid), 64'h1F);
        chk(in_ready == 0, "R8 not ready partial", 64'(in_ready), 0);
        @(negedge clk); #1;
        chk(out_valid == 5'b01110, "R8 no re-offer", 64'(out_valid), 64'hE);
        chk(in_ready == 0, "R8 still held", 64'(in_ready), 0);
        out_ready = '1;
        #1;
        chk(in_ready == 5'b10000, "R8 complete", 64'(in_ready), 64'h10);
        @(posedge clk); #1;
        in_valid[4] = 1'b0;
        #1;
        chk(in_ready == 5'b00001, "R9 next input", 64'(in_ready), 64'h1);
        chk(out_valid == 5'b10000, "R1 north to local", 64'(out_valid), 64'h10);
        @(posedge clk); #1;
        in_valid = '0;

        // Sweep every position of a 4x4 mesh
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                for (int s = 0; s < NP; s++) begin
                    logic [11:0] uh;
                    uh = {6'((r + s) % 4), 6'((c + s + 1) % 4)};
                    run_txn("R4 R5 R6 mc match", s, r, c, 1'b1, 2'b10, MC, {GRP, 20'h00100});
                    run_txn("R4 R5 R6 mc nomatch", s, r, c, 1'b1, 2'b00, MC, {GRP ^ 12'h001, 20'h0});
                    run_txn("R2 R3 mc read", s, r, c, 1'b0, 2'b10, MC, {uh, 20'h00200});
                    run_txn("R2 R3 mc 64-bit", s, r, c, 1'b1, 2'b11, MC, {uh, 20'h00300});
                    run_txn("R2 other ctrl", s, r, c, 1'b1, 2'b01, 4'h5, {uh, 20'h00400});
                end
                for (int dr = 0; dr < 4; dr++)
                    for (int dc = 0; dc < 4; dc++)
                        run_txn("R1 unicast", 4, r, c, 1'b1, 2'b10, 4'h0,
                                {6'(dr), 6'(dc), 20'h00500});
            end
        end
        finished = 1'b1;
    end

    initial begin : watchdog
        int cyc;
        cyc = 0;
        while (!finished && cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule